// File: doc/BRIEF.md
# Bidirectional Port Controller with Pulse-Width Takeover

This block controls an 8-pin general-purpose port for a bus master. Software programs a value register and a direction register. A third register returns the pin levels after a two-flop synchronizer. Each pin gets an output-enable and an output level.

An external pulse-width generator can claim any pin. While its channel enable is high, the pin drives the generator's waveform, whatever software programmed. The highest pin also accepts a shutdown request, which releases that pin to input even when its channel is active.

Neither a takeover nor a shutdown changes the stored direction bits, so software reads back the value it last wrote. The input register always shows the synchronized pin level, including on pins that are driving. Comparing the two lets software detect an output that is shorted or overloaded.

Top module: `gpio_pwm_port`

## Requirements
- R1: Asynchronous active-low reset clears the value register, the direction register and both synchronizer stages. Every `pin_oe` bit is 0 during and after reset until software writes the direction register.
- R2: Offset 1 is the direction register. A 1 in a bit means output, a 0 means input. It can be read and written at any time. With no takeover and no shutdown, `pin_oe` equals the stored direction bits.
- R3: When bit i of `pwm_en` is high and pin i is not shut down, `pin_oe[i]` is 1 and `pin_out[i]` equals `pwm_out[i]`. The stored direction bit is left unchanged.
- R4: When `shdn_en` is high, the top pin (bit 7) has `pin_oe` 0, even if its direction bit or its `pwm_en` bit is set. Its stored direction bit is left unchanged.
- R5: Offset 2 is the input register. It returns `pin_in` as sampled two rising clock edges earlier, on every pin, including pins whose `pin_oe` is 1.
- R6: A read of offset 0 returns, per bit, the stored value bit where `pin_oe` is 1 and the synchronized pin level where `pin_oe` is 0.
- R7: On a pin that is not taken over, `pin_out` equals the stored value bit. Offset 0 writes the value register on the clock edge that samples `bus_we`.
- R8: Writes to offset 2 change no register. The value and direction registers keep their contents.
- R9: Offset 3 reads as zero, and writes to it are ignored. Read data is combinational from `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset: 0 value, 1 direction, 2 input, 3 unused |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pwm_en | input | 8 | Per-pin pulse-width channel enable |
| pwm_out | input | 8 | Per-pin pulse-width waveform |
| shdn_en | input | 1 | Shutdown request for the top pin |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |

## Verification
The bench holds an external level that disagrees with a driven pin. A design that read the output register instead of the pad would hide the short.

It moves `pin_in` and reads the input register before the first clock edge, after it, and after the second edge. This catches a synchronizer that is one stage short or one stage long.

It raises shutdown together with both a channel enable and a set direction bit on the top pin. This exposes a priority that lets the takeover win. After each takeover and each shutdown it reads the direction register, to catch a design that overwrites the stored bit.

Writes to the input offset and the unused offset are followed by readback of the stored registers. A long stretch of random bus traffic is compared every cycle against a behavioural model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Register offsets on the bus; order matters to software only.
    localparam int unsigned OFS_VAL = 0;
    localparam int unsigned OFS_DIR = 1;
    localparam int unsigned OFS_IN  = 2;

    // Effective mode of one pin after takeover and shutdown are resolved.
    typedef enum logic [1:0] {
        MODE_IN   = 2'd0,
        MODE_OUT  = 2'd1,
        MODE_PWM  = 2'd2,
        MODE_SHDN = 2'd3
    } pin_mode_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  val_q,
    output logic [W-1:0]  dir_q
);
    import gpio_pkg::*;

    localparam logic [AW-1:0] A_VAL = AW'(OFS_VAL);
    localparam logic [AW-1:0] A_DIR = AW'(OFS_DIR);

    typedef struct packed {
        logic [W-1:0] val;
        logic [W-1:0] dir;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr == A_VAL) st_d.val = wdata;
            if (addr == A_DIR) st_d.dir = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_q = st_q.val;
    assign dir_q = st_q.dir;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.chain[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int W        = 8,
    parameter int SHDN_PIN = 7
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] val_q,
    input  logic [W-1:0] pwm_en,
    input  logic [W-1:0] pwm_out,
    input  logic         shdn_en,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    import gpio_pkg::*;

    pin_mode_e mode [W];

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == SHDN_PIN) begin : g_shdn
            // Shutdown outranks the takeover, which outranks software.
            always_comb begin
                if (shdn_en)        mode[i] = MODE_SHDN;
                else if (pwm_en[i]) mode[i] = MODE_PWM;
                else if (dir_q[i])  mode[i] = MODE_OUT;
                else                mode[i] = MODE_IN;
            end
        end else begin : g_plain
            always_comb begin
                if (pwm_en[i])     mode[i] = MODE_PWM;
                else if (dir_q[i]) mode[i] = MODE_OUT;
                else               mode[i] = MODE_IN;
            end
        end

        always_comb begin
            unique case (mode[i])
                MODE_PWM: begin
                    pin_oe[i]  = 1'b1;
                    pin_out[i] = pwm_out[i];
                end
                MODE_OUT: begin
                    pin_oe[i]  = 1'b1;
                    pin_out[i] = val_q[i];
                end
                default: begin
                    pin_oe[i]  = 1'b0;
                    pin_out[i] = val_q[i];
                end
            endcase
        end
    end
endmodule

// File: rtl/gpio_pwm_port.sv
module gpio_pwm_port #(
    parameter int PIN_W       = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SHDN_PIN    = PIN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pwm_en,
    input  logic [PIN_W-1:0]  pwm_out,
    input  logic              shdn_en,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    import gpio_pkg::*;

    localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(OFS_VAL);
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(OFS_IN);

    logic [PIN_W-1:0] val_q;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] pin_sync;

    gpio_regs #(.W(PIN_W), .AW(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .val_q (val_q),
        .dir_q (dir_q)
    );

    gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_pin_mux #(.W(PIN_W), .SHDN_PIN(SHDN_PIN)) u_mux (
        .dir_q   (dir_q),
        .val_q   (val_q),
        .pwm_en  (pwm_en),
        .pwm_out (pwm_out),
        .shdn_en (shdn_en),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    // Driven pins return the latched value, released pins the pad level.
    always_comb begin
        if (bus_addr == A_VAL)      bus_rdata = (val_q & pin_oe) | (pin_sync & ~pin_oe);
        else if (bus_addr == A_DIR) bus_rdata = dir_q;
        else if (bus_addr == A_IN)  bus_rdata = pin_sync;
        else                        bus_rdata = '0;
    end
endmodule

// File: rtl/gpio_pwm_port_chk.sv
module gpio_pwm_port_chk #(
    parameter int W        = 8,
    parameter int AW       = 2,
    parameter int SHDN_PIN = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  pwm_en,
    input logic [W-1:0]  pwm_out,
    input logic          shdn_en,
    input logic [W-1:0]  pin_in,
    input logic [W-1:0]  pin_out,
    input logic [W-1:0]  pin_oe,
    input logic [W-1:0]  val_q,
    input logic [W-1:0]  dir_q
);
    logic [W-1:0] shdn_mask;
    logic [W-1:0] own;
    logic [1:0]   age_q;

    assign shdn_mask = shdn_en ? (W'(1) << SHDN_PIN) : '0;
    assign own       = pwm_en & ~shdn_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_shdn_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_en |-> !pin_oe[SHDN_PIN]);

    assert_pwm_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((own & ~pin_oe) == '0) && ((own & (pin_out ^ pwm_out)) == '0));

    assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en == '0 && !shdn_en) |-> (pin_oe == dir_q));

    assert_dir_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == AW'(1)) |=> $stable(dir_q));

    assert_in_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(2)) |=> ($stable(dir_q) && $stable(val_q)));

    assert_sync_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && bus_addr == AW'(2)) |-> (bus_rdata == $past(pin_in, 2)));

    assert_val_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(0)) |-> ((bus_rdata & pin_oe) == (val_q & pin_oe)));

    assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(3)) |-> (bus_rdata == '0));
endmodule

bind gpio_pwm_port gpio_pwm_port_chk #(
    .W        (PIN_W),
    .AW       (ADDR_W),
    .SHDN_PIN (SHDN_PIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pwm_en    (pwm_en),
    .pwm_out   (pwm_out),
    .shdn_en   (shdn_en),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .val_q     (val_q),
    .dir_q     (dir_q)
);

// File: tb/gpio_pwm_port_bench.sv
module gpio_pwm_port_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pwm_en = '0;
    logic [W-1:0] pwm_out = '0;
    logic         shdn_en = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    gpio_pwm_port u_gpio_pwm_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_en    (pwm_en),
        .pwm_out   (pwm_out),
        .shdn_en   (shdn_en),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: stored registers plus a queue of pad samples.
    logic [W-1:0] m_val = '0;
    logic [W-1:0] m_dir = '0;
    logic [W-1:0] m_hist [$];

    function automatic logic [W-1:0] m_sync();
        return m_hist.size() >= 2 ? m_hist[m_hist.size()-2] : '0;
    endfunction

    function automatic logic [W-1:0] m_oe();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (i == W-1 && shdn_en) r[i] = 1'b0;
            else if (pwm_en[i])      r[i] = 1'b1;
            else                     r[i] = m_dir[i];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] m_out();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (pwm_en[i] && !(i == W-1 && shdn_en)) r[i] = pwm_out[i];
            else                                      r[i] = m_val[i];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] m_rd();
        case (bus_addr)
            2'd0:    return (m_val & m_oe()) | (m_sync() & ~m_oe());
            2'd1:    return m_dir;
            2'd2:    return m_sync();
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_val = '0;
            m_dir = '0;
            m_hist.delete();
        end else begin
            if (bus_we && bus_addr == 2'd0) m_val = bus_wdata;
            if (bus_we && bus_addr == 2'd1) m_dir = bus_wdata;
            m_hist.push_back(pin_in);
            if (m_hist.size() > 2) void'(m_hist.pop_front());
        end
        #2;
        if (cmp_on && rst_n) begin
            check(shdn_en ? "R4" : (pwm_en != 0 ? "R3" : "R2"), "cycle pin_oe", pin_oe, m_oe());
            check("R7", "cycle pin_out", pin_out, m_out());
            check("R6", "cycle bus_rdata", bus_rdata, m_rd());
        end
    end

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [W-1:0] exp, string req, string what);
        bus_addr = a;
        #1;
        check(req, what, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "oe in reset", pin_oe, 8'h00);
        rd(2'd1, 8'h00, "R1", "dir in reset");
        rd(2'd0, 8'h00, "R1", "value in reset");
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        #1;
        check("R1", "oe after reset", pin_oe, 8'h00);

        // R2 direction write and readback
        wr(2'd1, 8'h0F);
        rd(2'd1, 8'h0F, "R2", "dir readback");
        check("R2", "oe follows dir", pin_oe, 8'h0F);

        // R7 value drives outputs; R6 mixed value read
        pin_in = 8'h3C;
        wr(2'd0, 8'hA5);
        check("R7", "pin_out from value", pin_out, 8'hA5);
        repeat (2) @(negedge clk);
        rd(2'd0, 8'h35, "R6", "value read mixes pad and latch");

        // R5 two-edge latency, on driven pins too (bit0 driven 1, pad 0)
        @(negedge clk);
        pin_in = 8'hC2;
        rd(2'd2, 8'h3C, "R5", "input before edge");
        @(negedge clk);
        rd(2'd2, 8'h3C, "R5", "input after one edge");
        @(negedge clk);
        rd(2'd2, 8'hC2, "R5", "input after two edges");
        check("R5", "driven pin still high", pin_out & 8'h01, 8'h01);

        // R3 takeover
        @(negedge clk);
        pwm_en = 8'h30; pwm_out = 8'h10;
        #1;
        check("R3", "oe with takeover", pin_oe, 8'h3F);
        check("R3", "out with takeover", pin_out, 8'h95);
        rd(2'd1, 8'h0F, "R3", "dir unchanged by takeover");
        rd(2'd0, 8'hE5, "R6", "value read with takeover");

        // R4 shutdown beats takeover and direction on top pin
        @(negedge clk);
        pwm_en = 8'hB0; pwm_out = 8'h90;
        #1;
        check("R3", "top pin taken over", pin_oe, 8'hBF);
        @(negedge clk);
        shdn_en = 1'b1;
        #1;
        check("R4", "shutdown releases top pin", pin_oe, 8'h3F);
        wr(2'd1, 8'h8F);
        #1;
        check("R4", "shutdown beats dir bit", pin_oe, 8'h3F);
        rd(2'd1, 8'h8F, "R4", "dir unchanged by shutdown");
        @(negedge clk);
        shdn_en = 1'b0;
        #1;
        check("R4", "top pin back after shutdown", pin_oe, 8'hBF);

        // R8 input-register writes ignored; R9 unused offset
        @(negedge clk);
        pwm_en = '0;
        wr(2'd2, 8'hFF);
        #1;
        check("R8", "value kept after input write", pin_out, 8'hA5);
        rd(2'd1, 8'h8F, "R8", "dir kept after input write");
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h00, "R9", "unused offset reads zero");
        rd(2'd1, 8'h8F, "R9", "dir kept after unused write");
        check("R9", "value kept after unused write", pin_out, 8'hA5);

        // Random traffic, compared every cycle against the model
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            bus_addr  = 2'($urandom_range(0, 3));
            bus_we    = ($urandom_range(0, 3) == 0);
            bus_wdata = 8'($urandom);
            pin_in    = 8'($urandom);
            pwm_en    = ($urandom_range(0, 1) == 0) ? 8'($urandom) : 8'h00;
            pwm_out   = 8'($urandom);
            shdn_en   = ($urandom_range(0, 4) == 0);
        end
        @(negedge clk);
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule